// File: doc/BRIEF.md
# Load/Store Address Generator

This block forms the memory address for a single-word or unsigned-byte load or store, along with the value to write back into the base register. Each request carries a base value and an offset. The offset is either a zero-extended 12-bit immediate or a 32-bit value that an upstream shifter has already produced. The request also carries control bits that choose:

- whether the offset is added or subtracted,
- the indexing variant,
- the transfer size,
- the transfer direction.

Three indexing variants are supported. Offset addressing reads the computed target and leaves the base unchanged. Pre-indexed addressing reads the target and writes it back into the base. Post-indexed addressing reads the unmodified base and always writes the target back.

The block accepts at most one request per cycle, qualified by `in_valid`. It returns the registered result one cycle later, qualified by `out_valid`. Memory access and alignment handling belong to the stages that consume these outputs.

Top module: `ls_addr_gen`

## Requirements
- R1: `out_valid` is low while reset is active. It is high in a cycle exactly when `in_valid` was high in the previous cycle.
- R2: The target is `base + offset` when `add_off`=1 and `base - offset` when `add_off`=0.
- R3: When `off_is_reg`=0 the offset is `imm_off` zero-extended to 32 bits. When `off_is_reg`=1 the offset is `reg_off`.
- R4: When `pre_idx`=1 and `wb_req`=0, `addr` equals the target and `wb_en` is low.
- R5: When `pre_idx`=1 and `wb_req`=1, `addr` equals the target, `wb_en` is high and `wb_value` equals the target.
- R6: When `pre_idx`=0, `addr` equals the unmodified base, `wb_en` is high and `wb_value` equals the target, whatever the value of `wb_req`.
- R7: `byte_sel` repeats the request's `byte_xfer` bit (1 = unsigned byte, 0 = word). `load_flag` repeats `is_load` (1 = load, 0 = store).
- R8: `wb_en` is never high in a cycle where `out_valid` is low.
- R9: In a cycle with `in_valid` low, `addr`, `wb_value`, `byte_sel` and `load_flag` keep their previous values.
- R10: Address arithmetic wraps modulo 2^32 in both directions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Request present this cycle |
| base | input | 32 | Base register value |
| imm_off | input | 12 | Unsigned immediate offset |
| reg_off | input | 32 | Register or shifted-register offset from the shifter |
| off_is_reg | input | 1 | 1 selects `reg_off`, 0 selects `imm_off` |
| pre_idx | input | 1 | 1 = offset or pre-indexed, 0 = post-indexed |
| add_off | input | 1 | 1 adds the offset, 0 subtracts it |
| byte_xfer | input | 1 | 1 = unsigned byte, 0 = word |
| wb_req | input | 1 | Writeback request for pre-indexed form |
| is_load | input | 1 | 1 = load, 0 = store |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| addr | output | 32 | Access address |
| byte_sel | output | 1 | Registered transfer size |
| load_flag | output | 1 | Registered direction |
| wb_value | output | 32 | Value for the base register |
| wb_en | output | 1 | Base register writeback enable |

## Verification
A wrong adder direction or offset selection corrupts `addr` or `wb_value` on the first valid output after the faulty request, exactly one cycle later. A mis-decoded indexing variant shows on that same cycle, either as a wrong `wb_en` level or as the base appearing where the target belongs. A broken clock enable or valid pipeline shows in the first idle cycle, as changed held outputs or a stray `out_valid`. Because of this, the reference model compares every output on every clock rather than only on valid cycles.

// File: rtl/ls_addr_pkg.sv
package ls_addr_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned IMM_W  = 12;

  typedef enum logic [1:0] {
    MODE_OFFSET = 2'd0,
    MODE_PRE    = 2'd1,
    MODE_POST   = 2'd2
  } idx_mode_e;
endpackage

// File: rtl/ls_rst_sync.sv
module ls_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/ls_offset_sel.sv
module ls_offset_sel #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IMM_W  = 12
) (
  input  logic [IMM_W-1:0]  imm_off,
  input  logic [DATA_W-1:0] reg_off,
  input  logic              use_reg,
  output logic [DATA_W-1:0] offset
);
  logic [DATA_W-1:0] imm_ext;

  generate
    if (IMM_W < DATA_W) begin : g_pad
      assign imm_ext = {{(DATA_W-IMM_W){1'b0}}, imm_off};
    end else begin : g_trunc
      assign imm_ext = imm_off[DATA_W-1:0];
    end
  endgenerate

  always_comb begin
    offset = use_reg ? reg_off : imm_ext;
  end
endmodule

// File: rtl/ls_target_calc.sv
module ls_target_calc #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] base,
  input  logic [DATA_W-1:0] offset,
  input  logic              add_off,
  output logic [DATA_W-1:0] target
);
  // Carry and borrow out are dropped, so the sum wraps modulo 2^DATA_W.
  always_comb begin
    if (add_off) target = base + offset;
    else         target = base - offset;
  end
endmodule

// File: rtl/ls_mode_decode.sv
module ls_mode_decode
  import ls_addr_pkg::*;
(
  input  logic      pre_idx,
  input  logic      wb_req,
  output idx_mode_e mode,
  output logic      use_base_addr,
  output logic      wb_needed
);
  always_comb begin
    if (!pre_idx)    mode = MODE_POST;   // wb_req has no say here
    else if (wb_req) mode = MODE_PRE;
    else             mode = MODE_OFFSET;
    use_base_addr = (mode == MODE_POST);
    wb_needed     = (mode != MODE_OFFSET);
  end
endmodule

// File: rtl/ls_addr_gen.sv
module ls_addr_gen
  import ls_addr_pkg::*;
#(
  parameter int unsigned DATA_W = WORD_W,
  parameter int unsigned IMM_W  = ls_addr_pkg::IMM_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] base,
  input  logic [IMM_W-1:0]  imm_off,
  input  logic [DATA_W-1:0] reg_off,
  input  logic              off_is_reg,
  input  logic              pre_idx,
  input  logic              add_off,
  input  logic              byte_xfer,
  input  logic              wb_req,
  input  logic              is_load,
  output logic              out_valid,
  output logic [DATA_W-1:0] addr,
  output logic              byte_sel,
  output logic              load_flag,
  output logic [DATA_W-1:0] wb_value,
  output logic              wb_en
);
  logic              rst_n_int;
  logic [DATA_W-1:0] offset;
  logic [DATA_W-1:0] target;
  idx_mode_e         mode;
  logic              use_base_addr;
  logic              wb_needed;

  logic [DATA_W-1:0] addr_d, addr_q;
  logic [DATA_W-1:0] wbv_d, wbv_q;
  logic              byte_d, byte_q;
  logic              load_d, load_q;
  logic              valid_d, valid_q;
  logic              wben_d, wben_q;
  logic              data_en;

  ls_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_int)
  );

  ls_offset_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_off (
    .imm_off(imm_off), .reg_off(reg_off), .use_reg(off_is_reg), .offset(offset)
  );

  ls_target_calc #(.DATA_W(DATA_W)) u_calc (
    .base(base), .offset(offset), .add_off(add_off), .target(target)
  );

  ls_mode_decode u_mode (
    .pre_idx(pre_idx), .wb_req(wb_req), .mode(mode),
    .use_base_addr(use_base_addr), .wb_needed(wb_needed)
  );

  // Next-state logic
  always_comb begin
    data_en = in_valid;
    addr_d  = use_base_addr ? base : target;
    wbv_d   = target;
    byte_d  = byte_xfer;
    load_d  = is_load;
    valid_d = in_valid;
    wben_d  = in_valid & wb_needed;
  end

  // Control registers: reset, updated every cycle
  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      valid_q <= 1'b0;
      wben_q  <= 1'b0;
    end else begin
      valid_q <= valid_d;
      wben_q  <= wben_d;
    end
  end

  // Data registers: no reset, written only on an accepted request
  always_ff @(posedge clk) begin
    if (data_en) begin
      addr_q <= addr_d;
      wbv_q  <= wbv_d;
      byte_q <= byte_d;
      load_q <= load_d;
    end
  end

  assign out_valid = valid_q;
  assign wb_en     = wben_q;
  assign addr      = addr_q;
  assign wb_value  = wbv_q;
  assign byte_sel  = byte_q;
  assign load_flag = load_q;
endmodule

// File: rtl/ls_addr_gen_chk.sv
module ls_addr_gen_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [DATA_W-1:0] base,
  input logic              pre_idx,
  input logic              wb_req,
  input logic              out_valid,
  input logic [DATA_W-1:0] addr,
  input logic [DATA_W-1:0] wb_value,
  input logic              wb_en
);
  logic past_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  p_valid_delay_r1: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (out_valid == $past(in_valid)));

  p_offset_nowb_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(in_valid && pre_idx && !wb_req)) |-> !wb_en);

  p_pre_wb_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(in_valid && pre_idx && wb_req)) |-> (wb_en && wb_value == addr));

  p_post_base_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(in_valid && !pre_idx)) |-> (wb_en && addr == $past(base)));

  p_wb_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !wb_en);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(past_ok) && $past(!in_valid)) |-> ($stable(addr) && $stable(wb_value)));
endmodule

bind ls_addr_gen ls_addr_gen_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n_int), .in_valid(in_valid), .base(base),
  .pre_idx(pre_idx), .wb_req(wb_req), .out_valid(out_valid),
  .addr(addr), .wb_value(wb_value), .wb_en(wb_en)
);

// File: tb/sim_ls_addr_gen.sv
module sim_ls_addr_gen;
  localparam time CLK_PERIOD = 10ns;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] base;
  logic [11:0] imm_off;
  logic [31:0] reg_off;
  logic        off_is_reg, pre_idx, add_off, byte_xfer, wb_req, is_load;
  logic        out_valid, byte_sel, load_flag, wb_en;
  logic [31:0] addr, wb_value;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  bit cmp_on = 0;

  ls_addr_gen u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .base(base),
    .imm_off(imm_off), .reg_off(reg_off), .off_is_reg(off_is_reg),
    .pre_idx(pre_idx), .add_off(add_off), .byte_xfer(byte_xfer),
    .wb_req(wb_req), .is_load(is_load), .out_valid(out_valid),
    .addr(addr), .byte_sel(byte_sel), .load_flag(load_flag),
    .wb_value(wb_value), .wb_en(wb_en)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference model state
  logic        m_valid, m_wb_en, m_have, m_byte, m_load;
  logic [31:0] m_addr, m_wbv;
  string       m_tag;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_wb_en <= 1'b0;
      m_have  <= 1'b0;
      m_tag   <= "R1";
    end else begin
      m_valid <= in_valid;
      m_wb_en <= 1'b0;
      if (in_valid) begin
        longint unsigned off, b, t;
        b   = base;
        off = off_is_reg ? reg_off : imm_off;
        t   = add_off ? (b + off) : (b + 64'h1_0000_0000 - off);
        t   = t % 64'h1_0000_0000;
        m_addr  <= pre_idx ? t[31:0] : base;
        m_wbv   <= t[31:0];
        m_wb_en <= !pre_idx || wb_req;
        m_byte  <= byte_xfer;
        m_load  <= is_load;
        m_have  <= 1'b1;
        m_tag   <= !pre_idx ? "R6" : (wb_req ? "R5" : "R4");
      end else begin
        m_tag <= "R9";
      end
    end
  end

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !finished) begin
      chk("R1 out_valid", {31'b0, out_valid}, {31'b0, m_valid});
      chk($sformatf("R8 %s wb_en", m_tag), {31'b0, wb_en}, {31'b0, m_wb_en});
      if (m_have) begin
        chk($sformatf("%s R2 R3 R10 addr", m_tag), addr, m_addr);
        chk($sformatf("%s R2 R3 R10 wb_value", m_tag), wb_value, m_wbv);
        chk($sformatf("%s R7 byte_sel", m_tag), {31'b0, byte_sel}, {31'b0, m_byte});
        chk($sformatf("%s R7 load_flag", m_tag), {31'b0, load_flag}, {31'b0, m_load});
      end
    end
  end

  task automatic send(input logic [31:0] b, input logic [11:0] imm, input logic [31:0] ro,
                      input logic i, input logic p, input logic u, input logic bb,
                      input logic w, input logic l);
    @(negedge clk);
    in_valid = 1'b1; base = b; imm_off = imm; reg_off = ro;
    off_is_reg = i; pre_idx = p; add_off = u; byte_xfer = bb; wb_req = w; is_load = l;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      base = $urandom; imm_off = 12'($urandom); reg_off = $urandom;
      pre_idx = 1'($urandom); wb_req = 1'($urandom); byte_xfer = 1'($urandom);
      is_load = 1'($urandom); add_off = 1'($urandom); off_is_reg = 1'($urandom);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; base = '0; imm_off = '0; reg_off = '0;
    off_is_reg = 0; pre_idx = 0; add_off = 0; byte_xfer = 0; wb_req = 0; is_load = 0;
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    chk("R1 reset out_valid", {31'b0, out_valid}, 32'd0);
    chk("R8 reset wb_en", {31'b0, wb_en}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cmp_on = 1;
    // R3 immediate, R2 add, R4 offset form, R7 word load
    send(32'h0000_1000, 12'h124, 32'hDEAD_BEEF, 0, 1, 1, 0, 0, 1);
    // R3 register offset, R2 subtract, R5 pre-indexed, R7 byte store
    send(32'h0000_2000, 12'hFFF, 32'h0000_0100, 1, 1, 0, 1, 1, 0);
    // R6 post-indexed with wb_req low and high
    send(32'h0000_3000, 12'h010, 32'h0, 0, 0, 1, 0, 0, 1);
    send(32'h0000_3000, 12'h010, 32'h0, 0, 0, 0, 1, 1, 0);
    idle(2); // R9 hold
    // R10 wraparound, both directions; R3 immediate maximum
    send(32'hFFFF_FFF0, 12'h020, 32'h0, 0, 1, 1, 0, 1, 1);
    send(32'h0000_0010, 12'h000, 32'h0000_0020, 1, 0, 0, 0, 0, 0);
    send(32'hFFFF_F800, 12'hFFF, 32'h0, 0, 1, 1, 1, 0, 1);
    idle(3);
    for (int n = 0; n < 400; n++) begin
      if (($urandom % 4) == 0) idle(1);
      else send($urandom, 12'($urandom), $urandom, 1'($urandom), 1'($urandom),
                1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    end
    idle(3);
    finish_run();
  end
endmodule